// File: doc/BRIEF.md
# SPI flash command filter

This block sits in the path between a SPI host master and a SPI flash device and checks each transaction the host starts. It watches the host's chip-select, clock and data-out lines in single-lane SPI mode 0, which it samples with the system clock. It collects the first byte of each frame as the opcode and looks for that opcode in a programmable allow-list. Each allow-list entry also states how many address bytes the opcode carries (none, three or four) and whether the access is a read or a write.

When an allowed opcode carries an address, the filter waits for the complete address. It then asks an external privilege lookup port whether the 16 KiB block that holds the address may be accessed in that direction. The lookup covers an address space of 256 MiB.

If the opcode is not on the list, or the privilege lookup refuses the access, the filter drives the flash chip-select high for the rest of the frame. This aborts the command at the flash. It also counts the refusal in a saturating counter and sets a sticky flag. Two control bits, single-bit passthrough and multi-bit passthrough, switch enforcement off. A self-clearing soft-reset control bit clears the counter and the flag and leaves the policy in place.

Top module: `spi_flash_cmd_filter`

## Requirements
- R1: After reset, flash_csn is high while host_csn is high, blk_count is 0, blk_seen is 0, ctl_q is 0 and priv_req is low.
- R2: flash_sclk and flash_mosi always equal host_sclk and host_mosi. flash_csn equals host_csn in any frame that has not been refused.
- R3: With enforcement active, an opcode that matches none of the entries 0 to tbl_count-1 drives flash_csn high within two clocks of the eighth rising SCLK edge. flash_csn then stays high until host_csn rises. Entries at or above tbl_count are never matched.
- R4: An allowed opcode whose entry has no address phase passes the whole frame and raises no privilege query.
- R5: For a 3-byte entry, priv_req pulses for one clock after the 32nd rising SCLK edge. At that time priv_blk equals address bit 23 down to 14, zero-extended, and priv_wr equals the entry's direction bit. If priv_grant is low in that clock, the frame is refused.
- R6: For a 4-byte entry, the query follows the 40th rising SCLK edge. An address of 0x1000_0000 or above is refused without any query.
- R7: With ctl_q bit 0 or bit 1 set, no frame is refused, no query is raised and the counter does not move.
- R8: Each refused frame increments blk_count by one and sets blk_seen. blk_count holds at its maximum value and never wraps.
- R9: Writing ctl_wdata bit 15 high makes ctl_q bit 15 read 1 for one clock. In the clock after that, blk_count is 0, blk_seen is 0 and ctl_q bit 15 is 0. The allow-list and ctl_q bits 1 and 0 keep their values.
- R10: Each allow-list entry is written as tbl_wdata bits 7 to 0 = opcode, bits 9 to 8 = address length (1 = three bytes, 2 = four bytes, 0 or 3 = no address), and bit 10 = direction (1 = write). When several entries match, the lowest index wins.
- R11: host_csn high restarts the bit count, so the next frame's opcode is the first 8 bits after host_csn falls, however many bits the previous frame had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI lines are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| host_csn | input | 1 | Chip-select from the host master, active low |
| host_sclk | input | 1 | SPI clock from the host (mode 0) |
| host_mosi | input | 1 | Serial data from the host |
| flash_csn | output | 1 | Chip-select toward the flash, forced high when a frame is refused |
| flash_sclk | output | 1 | SPI clock toward the flash |
| flash_mosi | output | 1 | Serial data toward the flash |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: bit 0 single passthrough, bit 1 multi passthrough, bit 15 soft reset |
| ctl_q | output | 16 | Control word read-back |
| tbl_we | input | 1 | Allow-list entry write strobe |
| tbl_idx | input | 5 | Entry index written |
| tbl_wdata | input | 11 | Entry: {direction, address length, opcode} |
| tbl_count | input | 6 | Number of entries in use, 0 to 32 |
| priv_req | output | 1 | Privilege query strobe |
| priv_wr | output | 1 | Direction of the queried access, 1 = write |
| priv_blk | output | 14 | 16 KiB block index being queried |
| priv_grant | input | 1 | Answer to the query, in the same clock |
| blk_count | output | 16 | Refused frames, saturating |
| blk_seen | output | 1 | Sticky flag: a frame has been refused |

## Verification
A bit counter that is wrong by even one bit shifts the captured opcode. flash_csn then rises, or fails to rise, at the end of the first byte, and priv_blk shows a shifted block index at the query after the last address bit. A frame state left over from a previous frame shows at the next opcode, because a legal opcode is refused or an illegal one passes. A counter or flag that misses a clear or an increment shows on blk_count and blk_seen at the next clock after the soft reset, or once the frame is refused.

// File: rtl/spif_pkg.sv
// Shared types of the SPI flash command filter: allow-list entry layout,
// address length codes and the per-frame decision state.
package spif_pkg;

    localparam int OPC_W = 8;

    // Address length code kept in each allow-list entry.
    typedef enum logic [1:0] {
        ALEN_NONE = 2'd0,
        ALEN_3B   = 2'd1,
        ALEN_4B   = 2'd2,
        ALEN_RSVD = 2'd3
    } alen_e;

    // One allow-list entry: {direction, address length, opcode}.
    typedef struct packed {
        logic             wr;
        alen_e            alen;
        logic [OPC_W-1:0] opc;
    } allow_ent_t;

    // Decision state of the frame in progress.
    typedef enum logic [1:0] {
        ST_OPC   = 2'd0,
        ST_ADDR  = 2'd1,
        ST_PASS  = 2'd2,
        ST_BLOCK = 2'd3
    } frame_st_e;

endpackage

// File: rtl/spif_frame_decoder.sv
// Serial frame decoder. Finds rising SCLK edges by comparing SCLK with its
// value one clock earlier, shifts MOSI in on each edge and counts the bits
// of the current frame. Assumes host_csn, sclk and mosi are already
// synchronous to clk and that SCLK is at most a quarter of clk.
module spif_frame_decoder #(
    parameter int SH_W   = 32,
    parameter int BCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn,
    input  logic              sclk,
    input  logic              mosi,
    output logic              bit_vld,
    output logic [BCNT_W-1:0] bit_cnt,
    output logic [SH_W-1:0]   shreg
);

    logic sclk_q;

    // Edge detect, shift, and frame bit count (restarted while csn is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            bit_vld <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            sclk_q  <= sclk;
            bit_vld <= 1'b0;
            if (csn) begin
                bit_cnt <= '0;
            end else if (sclk && !sclk_q) begin
                shreg   <= {shreg[SH_W-2:0], mosi};
                bit_vld <= 1'b1;
                if (bit_cnt != '1) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csn |=> (bit_cnt == '0 && !bit_vld));

endmodule

// File: rtl/spif_allow_table.sv
// Opcode allow-list. Holds DEPTH entries and compares the opcode with all
// of them in parallel. Only entries below `used` take part, and the lowest
// matching index supplies the attributes.
module spif_allow_table import spif_pkg::*; #(
    parameter  int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  allow_ent_t       wdata,
    input  logic [IDX_W:0]   used,
    input  logic [OPC_W-1:0] opc,
    output logic             hit,
    output allow_ent_t       ent
);

    allow_ent_t       ents_q [DEPTH];
    logic [DEPTH-1:0] match;

    // Entry storage, written one entry at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ents_q[i] <= '0;
            end
        end else if (we) begin
            ents_q[widx] <= wdata;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ((IDX_W+1)'(g) < used) && (ents_q[g].opc == opc);
    end

    // Priority select: the lowest matching index wins.
    always_comb begin
        hit = |match;
        ent = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                ent = ents_q[i];
            end
        end
    end

endmodule

// File: rtl/spif_status.sv
// Refusal bookkeeping: a saturating event counter and a sticky flag. Both
// are cleared by the soft reset, which takes priority over a new event.
module spif_status #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             seen
);

    // Count refusals without wrapping and remember that one happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (inc) begin
            seen <= 1'b1;
            if (cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && !clr) |=> cnt == '1);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> seen);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !seen));

endmodule

// File: rtl/spi_flash_cmd_filter.sv
// Inline SPI flash command filter (top). It passes the host SPI lines to
// the flash and decides once per frame whether to pass or refuse it. The
// opcode decision is made two clocks after the eighth rising SCLK edge.
// The address decision is made in the clock after the last address bit,
// using a privilege port that answers in that same clock. A refused frame
// has its flash chip-select held high until the host ends the frame.
module spi_flash_cmd_filter import spif_pkg::*; #(
    parameter  int TBL_DEPTH  = 32,
    parameter  int CNT_W      = 16,
    parameter  int SPACE_LOG2 = 28,
    parameter  int GRAN_LOG2  = 14,
    localparam int TBL_IDX_W  = $clog2(TBL_DEPTH),
    localparam int BLK_W      = SPACE_LOG2 - GRAN_LOG2,
    localparam int ENT_W      = $bits(allow_ent_t)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_csn,
    input  logic                 host_sclk,
    input  logic                 host_mosi,
    output logic                 flash_csn,
    output logic                 flash_sclk,
    output logic                 flash_mosi,
    input  logic                 ctl_we,
    input  logic [15:0]          ctl_wdata,
    output logic [15:0]          ctl_q,
    input  logic                 tbl_we,
    input  logic [TBL_IDX_W-1:0] tbl_idx,
    input  logic [ENT_W-1:0]     tbl_wdata,
    input  logic [TBL_IDX_W:0]   tbl_count,
    output logic                 priv_req,
    output logic                 priv_wr,
    output logic [BLK_W-1:0]     priv_blk,
    input  logic                 priv_grant,
    output logic [CNT_W-1:0]     blk_count,
    output logic                 blk_seen
);

    localparam int          ADDR_W   = 32;
    localparam int          BCNT_W   = 6;
    localparam int          BITS_3B  = OPC_W + 24;
    localparam int          BITS_4B  = OPC_W + 32;
    localparam logic [15:0] CTL_MASK = 16'h8003;

    logic              bit_vld;
    logic [BCNT_W-1:0] bit_cnt;
    logic [ADDR_W-1:0] shreg;
    logic              tbl_hit;
    allow_ent_t        tbl_ent;
    frame_st_e         state_q, state_d;
    logic              is4_q, wr_q;
    logic              enforce, op_done, addr_done, in_range, blk_ev;
    logic [ADDR_W-1:0] addr;
    logic              unused_lo;

    assign flash_sclk = host_sclk;
    assign flash_mosi = host_mosi;
    assign flash_csn  = host_csn | (state_q == ST_BLOCK);

    spif_frame_decoder #(
        .SH_W   (ADDR_W),
        .BCNT_W (BCNT_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .csn     (host_csn),
        .sclk    (host_sclk),
        .mosi    (host_mosi),
        .bit_vld (bit_vld),
        .bit_cnt (bit_cnt),
        .shreg   (shreg)
    );

    spif_allow_table #(
        .DEPTH (TBL_DEPTH)
    ) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .widx  (tbl_idx),
        .wdata (allow_ent_t'(tbl_wdata)),
        .used  (tbl_count),
        .opc   (shreg[OPC_W-1:0]),
        .hit   (tbl_hit),
        .ent   (tbl_ent)
    );

    spif_status #(
        .CNT_W (CNT_W)
    ) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl_q[15]),
        .inc   (blk_ev),
        .cnt   (blk_count),
        .seen  (blk_seen)
    );

    // Control word: passthrough bits kept, soft-reset bit lasts one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= ctl_wdata & CTL_MASK;
        end else begin
            ctl_q[15] <= 1'b0;
        end
    end

    assign enforce   = (ctl_q[1:0] == 2'b00);
    assign op_done   = bit_vld && (state_q == ST_OPC) && (bit_cnt == BCNT_W'(OPC_W));
    assign addr_done = bit_vld && (state_q == ST_ADDR) &&
                       (bit_cnt == (is4_q ? BCNT_W'(BITS_4B) : BCNT_W'(BITS_3B)));
    assign addr      = is4_q ? shreg : {8'h00, shreg[23:0]};
    assign in_range  = (addr[ADDR_W-1:SPACE_LOG2] == '0);
    assign priv_blk  = addr[SPACE_LOG2-1:GRAN_LOG2];
    assign priv_wr   = wr_q;
    assign priv_req  = addr_done && in_range && enforce;
    assign unused_lo = ^addr[GRAN_LOG2-1:0];

    // Next decision state and the refusal event of this clock.
    always_comb begin
        state_d = state_q;
        blk_ev  = 1'b0;
        if (host_csn) begin
            state_d = ST_OPC;
        end else if (op_done) begin
            if (!enforce) begin
                state_d = ST_PASS;
            end else if (!tbl_hit) begin
                state_d = ST_BLOCK;
                blk_ev  = 1'b1;
            end else if (tbl_ent.alen == ALEN_3B || tbl_ent.alen == ALEN_4B) begin
                state_d = ST_ADDR;
            end else begin
                state_d = ST_PASS;
            end
        end else if (addr_done) begin
            if (!enforce) begin
                state_d = ST_PASS;
            end else if (!in_range || !priv_grant) begin
                state_d = ST_BLOCK;
                blk_ev  = 1'b1;
            end else begin
                state_d = ST_PASS;
            end
        end
    end

    // Frame state and opcode attributes latched at the opcode decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPC;
            is4_q   <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (op_done) begin
                is4_q <= (tbl_ent.alen == ALEN_4B);
                wr_q  <= tbl_ent.wr;
            end
        end
    end

    // R3
    block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK && !host_csn) |=> flash_csn);

    // R7
    pass_no_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[1:0] != 2'b00 && !ctl_we && state_q != ST_BLOCK) |=> state_q != ST_BLOCK);

    // R5
    one_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_req |=> !priv_req);

    // R9
    srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[15] && !ctl_we) |=> !ctl_q[15]);

endmodule

// File: tb/spi_flash_cmd_filter_test.sv
`timescale 1ns/1ps
module spi_flash_cmd_filter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_csn, host_sclk, host_mosi;
    logic        flash_csn, flash_sclk, flash_mosi;
    logic        ctl_we;
    logic [15:0] ctl_wdata, ctl_q;
    logic        tbl_we;
    logic [4:0]  tbl_idx;
    logic [10:0] tbl_wdata;
    logic [5:0]  tbl_count;
    logic        priv_req, priv_wr, priv_grant;
    logic [13:0] priv_blk;
    logic [3:0]  blk_count;
    logic        blk_seen;

    logic [13:0] g_lo, g_hi;
    int          n_chk = 0;
    int          n_fail = 0;
    int          req_cnt = 0;
    int          last_blk = -1;
    int          last_wr = -1;

    always #5 clk = ~clk;

    spi_flash_cmd_filter #(.CNT_W(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_csn(host_csn), .host_sclk(host_sclk), .host_mosi(host_mosi),
        .flash_csn(flash_csn), .flash_sclk(flash_sclk), .flash_mosi(flash_mosi),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata), .tbl_count(tbl_count),
        .priv_req(priv_req), .priv_wr(priv_wr), .priv_blk(priv_blk), .priv_grant(priv_grant),
        .blk_count(blk_count), .blk_seen(blk_seen)
    );

    // Privilege responder: grants blocks g_lo..g_hi.
    assign priv_grant = (priv_blk >= g_lo) && (priv_blk <= g_hi);

    // Record every privilege query, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && priv_req) begin
            req_cnt  <= req_cnt + 1;
            last_blk <= int'(priv_blk);
            last_wr  <= int'(priv_wr);
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic write_entry(input int idx, input logic [7:0] op, input logic [1:0] alen, input logic wr);
        @(negedge clk);
        tbl_we    = 1'b1;
        tbl_idx   = 5'(idx);
        tbl_wdata = {wr, alen, op};
        @(negedge clk);
        tbl_we    = 1'b0;
    endtask

    task automatic set_ctl(input logic [15:0] v);
        @(negedge clk);
        ctl_we    = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic start_frame();
        @(negedge clk);
        host_csn = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        host_sclk = 1'b0;
        host_mosi = b;
        repeat (4) @(negedge clk);
        host_sclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic end_frame();
        host_sclk = 1'b0;
        repeat (2) @(negedge clk);
        host_csn = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_addr(input int nbytes, input logic [31:0] a);
        for (int i = nbytes - 1; i >= 0; i--) send_byte(a[8*i +: 8]);
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        chk("R1 flash_csn", int'(flash_csn), 1);
        chk("R1 blk_count", int'(blk_count), 0);
        chk("R1 blk_seen", int'(blk_seen), 0);
        chk("R1 ctl_q", int'(ctl_q), 0);
        chk("R1 priv_req", int'(priv_req), 0);
    endtask

    // R4 and R2: opcode without address passes without a query.
    task automatic t_no_addr();
        int r0 = req_cnt;
        start_frame();
        chk("R2 csn follows", int'(flash_csn), 0);
        host_mosi = 1'b1;
        #1;
        chk("R2 mosi follows", int'(flash_mosi), 1);
        send_byte(8'h05);
        chk("R2 sclk follows", int'(flash_sclk), int'(host_sclk));
        chk("R4 passes after opcode", int'(flash_csn), 0);
        send_byte(8'h00);
        chk("R4 passes in data", int'(flash_csn), 0);
        end_frame();
        chk("R4 no query", req_cnt - r0, 0);
        chk("R4 not counted", int'(blk_count), 0);
    endtask

    // R3 and R8: unlisted opcode and entry beyond the count are refused.
    task automatic t_unlisted();
        start_frame();
        send_byte(8'hAB);
        chk("R3 unlisted refused", int'(flash_csn), 1);
        send_byte(8'h00);
        chk("R3 held high", int'(flash_csn), 1);
        end_frame();
        chk("R8 count 1", int'(blk_count), 1);
        chk("R8 sticky", int'(blk_seen), 1);
        start_frame();
        send_byte(8'h20);
        chk("R3 entry beyond count", int'(flash_csn), 1);
        end_frame();
        chk("R8 count 2", int'(blk_count), 2);
    endtask

    // R5 and R10: 3-byte address queries and direction bit.
    task automatic t_addr3();
        int r0 = req_cnt;
        start_frame();
        send_byte(8'h03);
        send_addr(2, 32'h0000_00C0);
        chk("R5 no early refusal", int'(flash_csn), 0);
        send_byte(8'h00);
        chk("R5 granted passes", int'(flash_csn), 0);
        end_frame();
        chk("R5 one query", req_cnt - r0, 1);
        chk("R5 block index", last_blk, 3);
        chk("R10 read dir", last_wr, 0);
        start_frame();
        send_byte(8'h02);
        send_addr(3, 32'h0010_4000);
        chk("R5 denied refused", int'(flash_csn), 1);
        end_frame();
        chk("R5 denied block", last_blk, 65);
        chk("R10 write dir", last_wr, 1);
        chk("R8 count 3", int'(blk_count), 3);
    endtask

    // R6: 4-byte addresses, including one beyond the privilege space.
    task automatic t_addr4();
        int r0 = req_cnt;
        start_frame();
        send_byte(8'h13);
        send_addr(4, 32'h0000_8000);
        chk("R6 granted passes", int'(flash_csn), 0);
        end_frame();
        chk("R6 block index", last_blk, 2);
        start_frame();
        send_byte(8'h12);
        send_addr(4, 32'h0FFF_C000);
        chk("R6 denied refused", int'(flash_csn), 1);
        end_frame();
        chk("R6 top block", last_blk, 16383);
        chk("R6 two queries", req_cnt - r0, 2);
        start_frame();
        send_byte(8'h13);
        send_addr(4, 32'h1000_0000);
        chk("R6 out of space refused", int'(flash_csn), 1);
        end_frame();
        chk("R6 no query out of space", req_cnt - r0, 2);
        chk("R8 count 5", int'(blk_count), 5);
    endtask

    // R7: either passthrough bit disables enforcement.
    task automatic t_passthrough();
        int r0 = req_cnt;
        set_ctl(16'h0001);
        start_frame();
        send_byte(8'hAB);
        chk("R7 single passthrough", int'(flash_csn), 0);
        end_frame();
        set_ctl(16'h0002);
        start_frame();
        send_byte(8'h03);
        send_addr(3, 32'h0010_4000);
        chk("R7 multi passthrough", int'(flash_csn), 0);
        end_frame();
        chk("R7 no query", req_cnt - r0, 0);
        chk("R7 not counted", int'(blk_count), 5);
        set_ctl(16'h0000);
    endtask

    // R11: a short frame does not shift the next frame's opcode.
    task automatic t_restart();
        start_frame();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        end_frame();
        start_frame();
        send_byte(8'h05);
        chk("R11 opcode realigned", int'(flash_csn), 0);
        end_frame();
    endtask

    // R10: length code 3 means no address; table rewrite takes effect.
    task automatic t_encoding();
        int r0 = req_cnt;
        write_entry(5, 8'hC7, 2'd3, 1'b0);
        start_frame();
        send_byte(8'hC7);
        send_addr(3, 32'h00FF_FFFF);
        chk("R10 rewritten entry passes", int'(flash_csn), 0);
        end_frame();
        chk("R10 code 3 no query", req_cnt - r0, 0);
    endtask

    // R9: soft reset clears status and keeps policy.
    task automatic t_soft_reset();
        @(negedge clk);
        ctl_we    = 1'b1;
        ctl_wdata = 16'h8001;
        @(negedge clk);
        ctl_we    = 1'b0;
        chk("R9 bit15 visible", int'(ctl_q), 32769);
        @(negedge clk);
        chk("R9 bit15 self-clears", int'(ctl_q), 1);
        chk("R9 count cleared", int'(blk_count), 0);
        chk("R9 sticky cleared", int'(blk_seen), 0);
        set_ctl(16'h0000);
        start_frame();
        send_byte(8'h05);
        chk("R9 table kept allow", int'(flash_csn), 0);
        end_frame();
        start_frame();
        send_byte(8'hAB);
        chk("R9 table kept refuse", int'(flash_csn), 1);
        end_frame();
        chk("R9 count after", int'(blk_count), 1);
    endtask

    // R8: counter saturates (bench uses a 4-bit counter).
    task automatic t_saturate();
        for (int k = 0; k < 20; k++) begin
            start_frame();
            send_byte(8'hAB);
            end_frame();
        end
        chk("R8 saturated", int'(blk_count), 15);
        chk("R8 sticky kept", int'(blk_seen), 1);
    endtask

    initial begin
        rst_n = 1'b0;
        host_csn = 1'b1; host_sclk = 1'b0; host_mosi = 1'b0;
        ctl_we = 1'b0; ctl_wdata = '0;
        tbl_we = 1'b0; tbl_idx = '0; tbl_wdata = '0; tbl_count = '0;
        g_lo = 14'd0; g_hi = 14'd63;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        write_entry(0, 8'h03, 2'd1, 1'b0);
        write_entry(1, 8'h13, 2'd2, 1'b0);
        write_entry(2, 8'h02, 2'd1, 1'b1);
        write_entry(3, 8'h12, 2'd2, 1'b1);
        write_entry(4, 8'h05, 2'd0, 1'b0);
        write_entry(5, 8'h9F, 2'd0, 1'b0);
        write_entry(6, 8'h20, 2'd1, 1'b1);
        tbl_count = 6'd6;
        t_no_addr();
        t_unlisted();
        t_addr3();
        t_addr4();
        t_passthrough();
        t_restart();
        t_encoding();
        t_soft_reset();
        t_saturate();
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=done");
        report();
        $finish;
    end

endmodule